// File: doc/BRIEF.md
# Threshold-Gated Transmit Packet FIFO

This block buffers outgoing packet bytes between a host writer and a serial packet transmitter. Each stored entry is one data byte plus an end-of-packet tag. Bytes do not leave as soon as they arrive. The queue holds them until its occupancy climbs past a programmable high mark. It then keeps feeding the transmitter until a packet boundary is reached with the occupancy back at or below that mark. Because of this, a packet that has started is never stalled halfway for lack of a threshold crossing. A packet is only cut short by a real underrun.

A second programmable mark sets a low-water level. When occupancy falls under it, a sticky status bit is set and the interrupt line goes high, so the host knows to refill. Two further sticky error bits record a write that arrived while the queue was full and a packet that ran dry in mid-flight. Both thresholds, the status word and the current occupancy are reached through a small register port with an address, a write strobe and a read strobe. Framing, bit stuffing, CRC and serialisation belong to the transmitter that follows this block.

Top module: `txq_gate_fifo`

## Requirements
- R1: After reset, the high mark reads 0x40, the low mark reads 0x07, status reads 0x00, occupancy reads 0, tx_valid is low and irq is low.
- R2: The register map is: address 0 holds the high mark, address 1 holds the low mark, address 2 holds status and address 3 holds occupancy. Addresses 0 and 1 store bits [6:0] of a write, and bit 7 of both always reads 0.
- R3: Bytes and their end-of-packet tags reach tx_data/tx_eop in the order they were written. Address 3 reads the number of stored entries (0 to 128).
- R4: While idle, draining begins (tx_valid high in the next cycle, when the queue is not empty) once the occupancy at the end of a cycle exceeds the high mark. With both marks at zero, this happens after the first byte is stored.
- R5: Once draining has begun, it continues byte after byte. It ends only when an end-of-packet byte is taken and the occupancy after that cycle is at or below the high mark.
- R6: Status bit 0 (low-water) is set in the cycle after the occupancy goes from at-or-above the low mark to below it. irq is the value of that bit.
- R7: A read strobe at address 2 returns the status and clears bits 0, 1 and 2. An event in the same cycle still sets its bit.
- R8: A write while 128 entries are stored is discarded and sets status bit 1 (overflow).
- R9: If draining is active, a packet is partly sent and the queue is empty, tx_abort is high in that cycle, status bit 2 (underrun) is set, and draining stops.
- R10: While tx_valid is high and tx_ready is low, the presented byte and tag do not change and nothing is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Host writes one entry this cycle |
| wr_data | input | 8 | Byte to store |
| wr_eop | input | 1 | Byte is the last of its packet |
| tx_valid | output | 1 | A byte is offered to the transmitter |
| tx_data | output | 8 | Offered byte |
| tx_eop | output | 1 | Offered byte closes its packet |
| tx_ready | input | 1 | Transmitter takes the offered byte |
| tx_abort | output | 1 | Current packet ran dry and must be aborted |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status at address 2) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| irq | output | 1 | Low-water interrupt |

## Verification
The bench targets the hysteresis edge. Here the occupancy sits exactly at the high mark when an end-of-packet byte leaves. A design that compares with the wrong inequality would either stop one packet early or keep draining. It also targets the both-marks-zero setting, where a wrong compare would never start. It drives a full queue with an extra write, which a faulty design would store by overwriting the oldest entry or miscount. It also starves a packet in mid-flight, which a faulty design would leave hanging with tx_valid low and no abort. Status reads that coincide with new events check that a clear does not swallow a fresh event.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int REG_W = 8;
  localparam int RA_W  = 2;

  localparam logic [RA_W-1:0] RA_HIGH   = 2'd0;
  localparam logic [RA_W-1:0] RA_LOW    = 2'd1;
  localparam logic [RA_W-1:0] RA_STATUS = 2'd2;
  localparam logic [RA_W-1:0] RA_LEVEL  = 2'd3;

  typedef struct packed {
    logic underrun;
    logic overflow;
    logic low_water;
  } txq_stat_t;
endpackage

// File: rtl/txq_store.sv
module txq_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 128,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic [DATA_W:0]   push_ent,
  input  logic              pop,
  output logic [DATA_W:0]   head,
  output logic [CNT_W-1:0]  fill,
  output logic [CNT_W-1:0]  fill_nxt,
  output logic              empty,
  output logic              full,
  output logic              ovf_evt
);
  logic [DATA_W:0]  mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_ptr_n, rd_ptr_n;
  logic             push_ok;

  assign full     = (fill == CNT_W'(DEPTH));
  assign empty    = (fill == '0);
  assign push_ok  = push_req & ~full;
  assign ovf_evt  = push_req & full;
  assign head     = mem[rd_ptr];
  assign fill_nxt = fill + CNT_W'(push_ok) - CNT_W'(pop);

  always_comb begin
    wr_ptr_n = wr_ptr;
    rd_ptr_n = rd_ptr;
    if (push_ok) wr_ptr_n = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
    if (pop)     rd_ptr_n = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_ent;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      wr_ptr <= wr_ptr_n;
      rd_ptr <= rd_ptr_n;
      fill   <= fill_nxt;
    end
  end
endmodule

// File: rtl/txq_gate.sv
module txq_gate #(
  parameter int CNT_W = 8,
  parameter int THR_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] fill_nxt,
  input  logic [THR_W-1:0] high_mark,
  input  logic             empty,
  input  logic             head_eop,
  input  logic             tx_ready,
  output logic             tx_valid,
  output logic             pop,
  output logic             abort
);
  logic active, active_n;
  logic in_pkt, in_pkt_n;
  logic above;

  assign above    = fill_nxt > CNT_W'(high_mark);
  assign tx_valid = active & ~empty;
  assign pop      = tx_valid & tx_ready;
  assign abort    = active & in_pkt & empty;

  always_comb begin
    active_n = active;
    in_pkt_n = in_pkt;
    if (abort) begin
      active_n = 1'b0;
      in_pkt_n = 1'b0;
    end else begin
      if (!active)
        active_n = above;
      else if (pop && head_eop)
        active_n = above;
      if (pop) in_pkt_n = ~head_eop;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      in_pkt <= 1'b0;
    end else begin
      active <= active_n;
      in_pkt <= in_pkt_n;
    end
  end
endmodule

// File: rtl/txq_regs.sv
module txq_regs
  import txq_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int THR_W = 7,
  parameter logic [THR_W-1:0] HIGH_RST = 7'h40,
  parameter logic [THR_W-1:0] LOW_RST  = 7'h07
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [RA_W-1:0]  reg_addr,
  input  logic [THR_W-1:0] reg_wval,
  input  logic [CNT_W-1:0] fill,
  input  logic             ovf_evt,
  input  logic             unf_evt,
  output logic [THR_W-1:0] high_mark,
  output logic [THR_W-1:0] low_mark,
  output txq_stat_t        stat,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq
);
  logic [THR_W-1:0] high_n, low_n;
  txq_stat_t        stat_n;
  logic             below, below_q;

  assign below = fill < CNT_W'(low_mark);
  assign irq   = stat.low_water;

  always_comb begin
    high_n = high_mark;
    low_n  = low_mark;
    if (reg_wr && reg_addr == RA_HIGH) high_n = reg_wval;
    if (reg_wr && reg_addr == RA_LOW)  low_n  = reg_wval;
  end

  always_comb begin
    stat_n = stat;
    if (reg_rd && reg_addr == RA_STATUS) stat_n = '0;
    if (below && !below_q) stat_n.low_water = 1'b1;
    if (ovf_evt)           stat_n.overflow  = 1'b1;
    if (unf_evt)           stat_n.underrun  = 1'b1;
  end

  always_comb begin
    case (reg_addr)
      RA_HIGH:   reg_rdata = REG_W'(high_mark);
      RA_LOW:    reg_rdata = REG_W'(low_mark);
      RA_STATUS: reg_rdata = REG_W'(stat);
      default:   reg_rdata = REG_W'(fill);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      high_mark <= HIGH_RST;
      low_mark  <= LOW_RST;
      stat      <= '0;
      below_q   <= 1'b1;
    end else begin
      high_mark <= high_n;
      low_mark  <= low_n;
      stat      <= stat_n;
      below_q   <= below;
    end
  end
endmodule

// File: rtl/txq_gate_fifo.sv
module txq_gate_fifo
  import txq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 128,
  parameter int THR_W  = 7,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_eop,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_eop,
  input  logic              tx_ready,
  output logic              tx_abort,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq
);
  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic [DATA_W:0]  head;
  logic [CNT_W-1:0] fill, fill_nxt;
  logic             empty, full, ovf_evt, pop;
  logic [THR_W-1:0] high_mark, low_mark;
  txq_stat_t        stat;
  logic             unused_wbits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n   = rst_pipe[1];
  assign unused_wbits = ^reg_wdata[REG_W-1:THR_W];

  assign tx_data = head[DATA_W-1:0];
  assign tx_eop  = head[DATA_W];

  txq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .push_req (wr_en),
    .push_ent ({wr_eop, wr_data}),
    .pop      (pop),
    .head     (head),
    .fill     (fill),
    .fill_nxt (fill_nxt),
    .empty    (empty),
    .full     (full),
    .ovf_evt  (ovf_evt)
  );

  txq_gate #(.CNT_W(CNT_W), .THR_W(THR_W)) u_gate (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .fill_nxt  (fill_nxt),
    .high_mark (high_mark),
    .empty     (empty),
    .head_eop  (head[DATA_W]),
    .tx_ready  (tx_ready),
    .tx_valid  (tx_valid),
    .pop       (pop),
    .abort     (tx_abort)
  );

  txq_regs #(.CNT_W(CNT_W), .THR_W(THR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wval  (reg_wdata[THR_W-1:0]),
    .fill      (fill),
    .ovf_evt   (ovf_evt),
    .unf_evt   (tx_abort),
    .high_mark (high_mark),
    .low_mark  (low_mark),
    .stat      (stat),
    .reg_rdata (reg_rdata),
    .irq       (irq)
  );
endmodule

// File: rtl/txq_gate_fifo_chk.sv
module txq_gate_fifo_chk
  import txq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 128,
  parameter int THR_W  = 7,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              tx_valid,
  input logic [DATA_W-1:0] tx_data,
  input logic              tx_eop,
  input logic              tx_ready,
  input logic              tx_abort,
  input logic [CNT_W-1:0]  fill,
  input logic [THR_W-1:0]  low_mark,
  input txq_stat_t         stat,
  input logic [RA_W-1:0]   reg_addr,
  input logic [REG_W-1:0]  reg_rdata,
  input logic              irq
);
  // R3
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CNT_W'(DEPTH));

  // R8
  overflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fill == CNT_W'(DEPTH)) |=> stat.overflow);

  // R9
  abort_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |=> !tx_valid);

  // R5
  mid_packet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && !tx_eop) |=> (tx_valid || tx_abort));

  // R6
  low_water_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(fill) < CNT_W'($past(low_mark))));

  // R2
  reserved_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == RA_HIGH || reg_addr == RA_LOW) |-> !reg_rdata[REG_W-1]);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_eop)));
endmodule

bind txq_gate_fifo txq_gate_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .THR_W(THR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .wr_en     (wr_en),
  .tx_valid  (tx_valid),
  .tx_data   (tx_data),
  .tx_eop    (tx_eop),
  .tx_ready  (tx_ready),
  .tx_abort  (tx_abort),
  .fill      (fill),
  .low_mark  (low_mark),
  .stat      (stat),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .irq       (irq)
);

// File: tb/txq_gate_fifo_test.sv
module txq_gate_fifo_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_eop = 1'b0, tx_ready = 1'b0;
  logic [7:0] wr_data = '0, reg_wdata = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       tx_valid, tx_eop, tx_abort, irq;
  logic [7:0] tx_data, reg_rdata;

  int checks = 0, fails = 0;
  logic [8:0] mq[$];
  int  m_hi = 64, m_lo = 7;
  bit  m_act = 0, m_pkt = 0, m_ovf = 0, m_unf = 0, m_lw = 0, m_lwq = 1;
  logic [7:0] last_rd;
  logic       last_valid, last_abort;

  always #5 clk = ~clk;

  txq_gate_fifo uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_eop(wr_eop),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_eop(tx_eop), .tx_ready(tx_ready),
    .tx_abort(tx_abort), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_reg(input logic [1:0] a);
    case (a)
      2'd0:    return 8'(m_hi);
      2'd1:    return 8'(m_lo);
      2'd2:    return {5'b0, m_unf, m_ovf, m_lw};
      default: return 8'(mq.size());
    endcase
  endfunction

  // one clock of stimulus, output comparison against the model, then model update
  task automatic step(input logic w, input logic [7:0] d, input logic e, input logic rdy,
                      input logic rr, input logic rw, input logic [1:0] a, input logic [7:0] wd);
    int  fill, fnx;
    bit  ev, eab, pop, push, eop;
    @(negedge clk);
    wr_en = w; wr_data = d; wr_eop = e; tx_ready = rdy;
    reg_rd = rr; reg_wr = rw; reg_addr = a; reg_wdata = wd;
    #3;
    fill = mq.size();
    ev   = m_act && fill > 0;
    eab  = m_act && m_pkt && fill == 0;
    eop  = ev ? mq[0][8] : 1'b0;
    chk(tx_valid === ev, "R4/R5 tx_valid", tx_valid, ev);
    if (ev) chk({tx_eop, tx_data} === mq[0], "R3/R10 head entry", {tx_eop, tx_data}, mq[0]);
    chk(tx_abort === eab, "R9 tx_abort", tx_abort, eab);
    chk(irq === m_lw, "R6 irq", irq, m_lw);
    case (a)
      2'd0, 2'd1: chk(reg_rdata === exp_reg(a), "R2 threshold read", reg_rdata, exp_reg(a));
      2'd2:       chk(reg_rdata === exp_reg(a), "R7 status read", reg_rdata, exp_reg(a));
      default:    chk(reg_rdata === exp_reg(a), "R3 occupancy read", reg_rdata, exp_reg(a));
    endcase
    last_rd = reg_rdata; last_valid = tx_valid; last_abort = tx_abort;
    @(posedge clk);
    pop  = ev && rdy;
    push = w && fill < 128;
    fnx  = fill + int'(push) - int'(pop);
    if (rr && a == 2'd2) begin m_lw = 0; m_ovf = 0; m_unf = 0; end
    if (fill < m_lo && !m_lwq) m_lw = 1;
    m_lwq = (fill < m_lo);
    if (w && fill == 128) m_ovf = 1;
    if (eab) begin
      m_unf = 1; m_act = 0; m_pkt = 0;
    end else begin
      if (!m_act) m_act = (fnx > m_hi);
      else if (pop && eop) m_act = (fnx > m_hi);
      if (pop) m_pkt = !eop;
    end
    if (pop) void'(mq.pop_front());
    if (push) mq.push_back({e, d});
    if (rw && a == 2'd0) m_hi = int'(wd[6:0]);
    if (rw && a == 2'd1) m_lo = int'(wd[6:0]);
  endtask

  task automatic idle(input logic rdy, input logic [1:0] a);
    step(1'b0, 8'h00, 1'b0, rdy, 1'b0, 1'b0, a, 8'h00);
  endtask

  task automatic set_marks(input int hi, input int lo);
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 8'(hi));
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 8'(lo));
  endtask

  task automatic drain(input int n);
    for (int i = 0; i < n; i++) idle(1'b1, 2'd3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset values
    idle(1'b0, 2'd0); chk(last_rd == 8'h40, "R1 high mark reset", last_rd, 8'h40);
    idle(1'b0, 2'd1); chk(last_rd == 8'h07, "R1 low mark reset", last_rd, 8'h07);
    idle(1'b0, 2'd2); chk(last_rd == 8'h00, "R1 status reset", last_rd, 0);
    idle(1'b0, 2'd3); chk(last_rd == 8'h00 && !last_valid && !irq, "R1 idle outputs", last_rd, 0);

    // R2 reserved bit
    step(1'b0, 0, 0, 0, 0, 1'b1, 2'd0, 8'hFF);
    idle(1'b0, 2'd0); chk(last_rd == 8'h7F, "R2 bit7 high mark", last_rd, 8'h7F);
    step(1'b0, 0, 0, 0, 0, 1'b1, 2'd1, 8'hC3);
    idle(1'b0, 2'd1); chk(last_rd == 8'h43, "R2 bit7 low mark", last_rd, 8'h43);

    // R4 both marks zero: start after the first stored byte
    set_marks(0, 0);
    step(1'b1, 8'hA5, 1'b1, 1'b0, 0, 0, 2'd3, 0);
    idle(1'b0, 2'd3); chk(last_valid === 1'b1, "R4 zero marks start", last_valid, 1);
    drain(2);

    // R9 underrun: lone non-final byte sent, queue runs dry
    step(1'b1, 8'h11, 1'b0, 1'b0, 0, 0, 2'd3, 0);
    idle(1'b1, 2'd3);
    idle(1'b1, 2'd3); chk(last_abort === 1'b1, "R9 abort on dry packet", last_abort, 1);
    step(1'b0, 0, 0, 1'b1, 1'b1, 0, 2'd2, 0);
    chk(last_rd[2] === 1'b1, "R9 underrun status", last_rd, 4);
    // R7 second read shows cleared error bits
    step(1'b0, 0, 0, 1'b1, 1'b1, 0, 2'd2, 0);
    chk(last_rd[2:1] === 2'b00, "R7 read clears", last_rd, 0);

    // R5 hysteresis: six-byte packet started at occupancy 5 drains fully
    set_marks(4, 1);
    for (int i = 0; i < 6; i++) step(1'b1, 8'(8'h20 + i), i == 5, 1'b0, 0, 0, 2'd3, 0);
    for (int i = 0; i < 6; i++) begin
      idle(1'b1, 2'd3);
      chk(last_valid === 1'b1, "R5 keeps draining", last_valid, 1);
    end
    idle(1'b1, 2'd3); chk(last_valid === 1'b0, "R5 stops at boundary", last_valid, 0);

    // R8 overflow: fill all 128 entries with the transmitter stalled, then one more
    set_marks(127, 5);
    for (int i = 0; i < 129; i++) step(1'b1, 8'(i), (i % 7) == 6, 1'b0, 0, 0, 2'd3, 0);
    step(1'b0, 0, 0, 1'b0, 1'b1, 0, 2'd2, 0);
    chk(last_rd[1] === 1'b1, "R8 overflow status", last_rd, 2);
    idle(1'b0, 2'd3); chk(last_rd == 8'd128, "R8 discarded write", last_rd, 128);
    drain(200);

    // constrained random phases
    for (int ph = 0; ph < 12; ph++) begin
      int hi, lo, wp, rp;
      hi = $urandom_range(0, 127);
      lo = (hi == 0) ? 0 : $urandom_range(0, hi - 1);
      wp = $urandom_range(10, 95);
      rp = $urandom_range(10, 95);
      set_marks(hi, lo);
      for (int c = 0; c < 1500; c++) begin
        logic [1:0] a;
        a = 2'($urandom_range(0, 3));
        step(($urandom % 100) < wp, 8'($urandom), ($urandom % 6) == 0,
             ($urandom % 100) < rp, ($urandom % 16) == 0, 1'b0, a, 8'h00);
      end
      drain(300);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule